// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

This block decides which of up to `NSRC` interrupt sources is presented to a small CPU, and when. Each source carries an individual enable and a priority level from 0 (lowest) to 3 (highest). One global enable masks every source at once. The lowest `NEXT` source indices come from external pins, and each pin can be set to level or falling-edge triggering. The remaining sources are internal request lines from peripherals.

The CPU pulses `boundary` at each instruction boundary, and the arbiter re-evaluates only on that clock. If the winning pending request may preempt the handlers already running, the arbiter raises `irq` with the source index and level. The CPU pulses `ack` when it takes the interrupt: the granted level is then marked as in service, and a latched edge flag of the granted pin is cleared. A `reti` pulse retires the highest in-service level. Because in-service levels are tracked one bit per level, handlers can nest up to four deep, and each nested handler has a strictly higher level than the one it preempted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset `irq` is 0, no level is in service and no edge flag is set.
- R2: While `glob_en` is 0, a `boundary` clock leaves `irq` at 0 whatever the sources request.
- R3: A source whose bit in `src_en` is 0 is never granted.
- R4: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}. When pending requests differ in level, the higher level is granted regardless of index.
- R5: Among pending requests of the same level, the lowest source index is granted.
- R6: While some level is in service, a request is granted only if its level is strictly above the highest in-service level. Equal or lower levels wait.
- R7: While level 3 is in service, no request is granted.
- R8: When an external pin is in edge mode (`ext_edge` bit 1), a clock sample reading 1 followed by a sample reading 0 latches a request. The request stays latched after the pin returns high, and an `ack` granting that source clears it.
- R9: When an external pin is in level mode (`ext_edge` bit 0), the pin requests while it is sampled 0 and stops requesting once it is sampled 1, with nothing to clear.
- R10: `irq`, `irq_src` and `irq_lvl` are registered. They change only on a `boundary` clock, or they drop to 0 on the clock after an `ack` while `irq` is 1.
- R11: `reti` retires only the highest in-service level. Lower in-service levels keep blocking requests at or below their level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NEXT | External interrupt pins; idle high |
| ext_edge | input | NEXT | Per-pin trigger mode: 1 falling edge, 0 low level |
| int_req | input | NSRC-NEXT | Internal requests for sources NEXT and above |
| src_en | input | NSRC | Per-source enable |
| glob_en | input | 1 | Global enable |
| prio_lo | input | NSRC | Low bit of each source's level |
| prio_hi | input | NSRC | High bit of each source's level |
| boundary | input | 1 | Instruction-boundary sample strobe |
| ack | input | 1 | CPU takes the presented interrupt |
| reti | input | 1 | Return from the current handler |
| irq | output | 1 | Interrupt request to the CPU |
| irq_src | output | $clog2(NSRC) | Granted source index |
| irq_lvl | output | 2 | Granted level |

## Verification
The bench builds the block with `NSRC` = 6 and `NEXT` = 2, which gives two pins (sources 0 and 1) and four internal lines (sources 2 to 5). With this size one pin can be tested in each trigger mode side by side. Every level has more than one candidate source, so fixed-index order and level order can be set against each other, as when a high index at a high level beats a low index at a low level. The small size also lets a full nest of two in-service levels be built and then unwound one `reti` at a time.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLVL = 4;
  typedef logic [1:0] lvl_t;
endpackage

// File: rtl/irq_ext_capture.sv
module irq_ext_capture #(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEXT-1:0] pin,
  input  logic [NEXT-1:0] edge_mode,
  input  logic [NEXT-1:0] clr,
  output logic [NEXT-1:0] req
);
  for (genvar i = 0; i < NEXT; i++) begin : g_pin
    logic smp, dly, flag;
    always_ff @(posedge clk) begin
      if (rst) begin
        smp  <= 1'b1;
        dly  <= 1'b1;
        flag <= 1'b0;
      end else begin
        smp <= pin[i];
        dly <= smp;
        if (!edge_mode[i])           flag <= 1'b0;
        else if (dly && !smp)        flag <= 1'b1;
        else if (clr[i])             flag <= 1'b0;
      end
    end
    assign req[i] = edge_mode[i] ? flag : ~smp;

    // R8: a high-then-low sample pair in edge mode latches a request
    p_edge_latch_r8: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[i] && dly && !smp) |=> (req[i] || !edge_mode[i]));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [NSRC-1:0] prio_hi,
  output logic            win_valid,
  output logic [SW-1:0]   win_idx,
  output lvl_t            win_lvl
);
  logic [NLVL-1:0] found;
  logic [SW-1:0]   idx_l [NLVL];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic          f;
    logic [SW-1:0] ix;
    always_comb begin
      f  = 1'b0;
      ix = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (pend[i] && ({prio_hi[i], prio_lo[i]} == 2'(l))) begin
          f  = 1'b1;
          ix = SW'(i);
        end
      end
    end
    assign found[l] = f;
    assign idx_l[l] = ix;
  end

  always_comb begin
    win_valid = |found;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (found[l]) begin
        win_idx = idx_l[l];
        win_lvl = 2'(l);
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic top_valid,
  output lvl_t top_lvl
);
  logic [NLVL-1:0] ins, pop_mask, push_mask;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++) if (ins[l]) top_lvl = 2'(l);
  end
  assign top_valid = |ins;
  assign pop_mask  = (pop && top_valid) ? (NLVL'(1) << top_lvl) : '0;
  assign push_mask = push ? (NLVL'(1) << push_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) ins <= '0;
    else     ins <= (ins & ~pop_mask) | push_mask;
  end

  // R6: a pushed level is in service on the next clock
  p_push_marks_r6: assert property (@(posedge clk) disable iff (rst)
    push |=> (top_valid && top_lvl >= $past(push_lvl)));
  // R11: a return alone removes the level that was on top
  p_pop_top_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && top_valid) |=> (!top_valid || top_lvl < $past(top_lvl)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NEXT = 2,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NEXT-1:0]      ext_pin,
  input  logic [NEXT-1:0]      ext_edge,
  input  logic [NSRC-NEXT-1:0] int_req,
  input  logic [NSRC-1:0]      src_en,
  input  logic                 glob_en,
  input  logic [NSRC-1:0]      prio_lo,
  input  logic [NSRC-1:0]      prio_hi,
  input  logic                 boundary,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irq,
  output logic [SW-1:0]        irq_src,
  output logic [1:0]           irq_lvl
);
  logic [NEXT-1:0] ext_req, ext_clr;
  logic [NSRC-1:0] pend;
  logic            win_valid, top_valid, grant_ok, take;
  logic [SW-1:0]   win_idx;
  lvl_t            win_lvl, top_lvl;

  irq_ext_capture #(.NEXT(NEXT)) u_cap (
    .clk(clk), .rst(rst), .pin(ext_pin), .edge_mode(ext_edge),
    .clr(ext_clr), .req(ext_req));

  assign pend = {int_req, ext_req} & src_en & {NSRC{glob_en}};

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .pend(pend), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl));

  assign take = ack && irq;

  irq_nest_stack u_stk (
    .clk(clk), .rst(rst), .push(take), .push_lvl(irq_lvl), .pop(reti),
    .top_valid(top_valid), .top_lvl(top_lvl));

  for (genvar i = 0; i < NEXT; i++) begin : g_clr
    assign ext_clr[i] = take && (irq_src == SW'(i));
  end

  assign grant_ok = win_valid && (!top_valid || win_lvl > top_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      irq_src <= '0;
      irq_lvl <= '0;
    end else if (take) begin
      irq <= 1'b0;
    end else if (boundary) begin
      irq     <= grant_ok;
      irq_src <= win_idx;
      irq_lvl <= win_lvl;
    end
  end

  // R6: a presented request always outranks every in-service level
  p_strict_preempt_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && top_valid) |-> (irq_lvl > top_lvl));
  // R7: nothing is presented while the top level is in service
  p_top_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (top_valid && top_lvl == 2'd3) |-> !irq);
  // R2: global disable blocks a grant at a boundary
  p_glob_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (boundary && !glob_en && !take) |=> !irq);
  // R10: acknowledge drops the request on the next clock
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq);
  // R10: outputs hold between boundaries
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!boundary && !ack) |=> ($stable(irq) && $stable(irq_src) && $stable(irq_lvl)));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int NSRC = 6;
  localparam int NEXT = 2;
  localparam int SW   = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst;
  logic [NEXT-1:0] ext_pin, ext_edge;
  logic [NSRC-NEXT-1:0] int_req;
  logic [NSRC-1:0] src_en, prio_lo, prio_hi;
  logic glob_en, boundary, ack, reti;
  logic irq;
  logic [SW-1:0] irq_src;
  logic [1:0] irq_lvl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .NEXT(NEXT)) dut_i (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .int_req(int_req), .src_en(src_en), .glob_en(glob_en),
    .prio_lo(prio_lo), .prio_hi(prio_hi), .boundary(boundary),
    .ack(ack), .reti(reti), .irq(irq), .irq_src(irq_src), .irq_lvl(irq_lvl));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit e_irq, int e_src, int e_lvl, string tag);
    checks++;
    if (irq !== e_irq || (e_irq && (irq_src !== SW'(e_src) || irq_lvl !== 2'(e_lvl)))) begin
      errors++;
      $display("FAIL %s: irq=%0b src=%0d lvl=%0d expected irq=%0b src=%0d lvl=%0d",
               tag, irq, irq_src, irq_lvl, e_irq, e_src, e_lvl);
    end
  endtask

  task automatic set_lvl(int idx, int l);
    prio_lo[idx] = l[0];
    prio_hi[idx] = l[1];
  endtask

  task automatic bnd();  boundary = 1; tick(); boundary = 0; endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic do_reti(); reti = 1; tick(); reti = 0; endtask

  task automatic quiet();
    int_req = '0; ext_pin = '1; prio_lo = '0; prio_hi = '0;
    src_en = '1; glob_en = 1; tick(3);
  endtask

  task automatic t_reset();
    chk(0, 0, 0, "R1 after reset");
    bnd();
    chk(0, 0, 0, "R1 nothing pending");
  endtask

  task automatic t_global();
    quiet();
    glob_en = 0; int_req[0] = 1; set_lvl(2, 1);
    bnd(); chk(0, 0, 0, "R2 global disable");
    glob_en = 1;
    bnd(); chk(1, 2, 1, "R2 global enable restored");
    int_req = '0; bnd();
  endtask

  task automatic t_src_en();
    quiet();
    int_req[1] = 1; src_en[3] = 0;
    bnd(); chk(0, 0, 0, "R3 source disabled");
    int_req[0] = 1;
    bnd(); chk(1, 2, 0, "R3 other source still granted");
    int_req = '0; bnd();
  endtask

  task automatic t_cross_level();
    quiet();
    int_req[0] = 1; set_lvl(2, 1);
    int_req[3] = 1; set_lvl(5, 2);
    bnd(); chk(1, 5, 2, "R4 higher level beats lower index");
    int_req[1] = 1; set_lvl(3, 3);
    bnd(); chk(1, 3, 3, "R4 level 3 from both priority bits");
    int_req = '0; bnd();
  endtask

  task automatic t_same_level();
    quiet();
    int_req[1] = 1; int_req[3] = 1; set_lvl(3, 1); set_lvl(5, 1);
    bnd(); chk(1, 3, 1, "R5 lower index wins at equal level");
    int_req[0] = 1; set_lvl(2, 1);
    bnd(); chk(1, 2, 1, "R5 new lowest index");
    int_req = '0; bnd();
  endtask

  task automatic t_nest();
    quiet();
    int_req[0] = 1; set_lvl(2, 1);
    bnd(); chk(1, 2, 1, "R6 first handler");
    do_ack(); int_req[0] = 0;
    int_req[2] = 1; set_lvl(4, 1);
    bnd(); chk(0, 0, 0, "R6 equal level blocked");
    int_req[3] = 1; set_lvl(5, 2);
    bnd(); chk(1, 5, 2, "R6 higher level preempts");
    do_ack(); int_req[3] = 0;
    bnd(); chk(0, 0, 0, "R6 lower level blocked in nest");
    do_reti();
    bnd(); chk(0, 0, 0, "R11 lower in-service level still blocks");
    do_reti();
    bnd(); chk(1, 4, 1, "R11 all levels retired");
    int_req = '0; bnd();
  endtask

  task automatic t_top_level();
    quiet();
    int_req[0] = 1; set_lvl(2, 3);
    bnd(); do_ack(); int_req[0] = 0;
    int_req[3] = 1; set_lvl(5, 3);
    int_req[1] = 1; set_lvl(3, 2);
    bnd(); chk(0, 0, 0, "R7 level 3 handler not preempted");
    do_reti();
    bnd(); chk(1, 5, 3, "R7 grant after return");
    int_req = '0; bnd();
  endtask

  task automatic t_edge();
    quiet();
    set_lvl(0, 1);
    bnd(); chk(0, 0, 0, "R8 idle high pin no request");
    ext_pin[0] = 0; tick(2); ext_pin[0] = 1; tick(3);
    bnd(); chk(1, 0, 1, "R8 latched falling edge");
    do_ack();
    bnd(); chk(0, 0, 0, "R8 flag cleared by ack");
    do_reti();
  endtask

  task automatic t_level();
    quiet();
    set_lvl(1, 2);
    ext_pin[1] = 0; tick(2);
    bnd(); chk(1, 1, 2, "R9 low level requests");
    ext_pin[1] = 1; tick(2);
    bnd(); chk(0, 0, 0, "R9 request follows pin high");
  endtask

  task automatic t_hold();
    quiet();
    int_req[2] = 1; set_lvl(4, 2);
    bnd(); int_req[2] = 0; tick(3);
    chk(1, 4, 2, "R10 output held without boundary");
    do_ack();
    chk(0, 0, 0, "R10 ack drops request");
    do_reti();
  endtask

  initial begin
    rst = 1; ext_pin = '1; ext_edge = 2'b01; int_req = '0;
    src_en = '1; glob_en = 1; prio_lo = '0; prio_hi = '0;
    boundary = 0; ack = 0; reti = 0;
    tick(3); rst = 0; tick();
    t_reset(); t_global(); t_src_en(); t_cross_level(); t_same_level();
    t_nest(); t_top_level(); t_edge(); t_level(); t_hold();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule